// File: doc/BRIEF.md
# Sprite Horizontal Position Counter

This block keeps the horizontal position of one sprite on a scanline-based video generator. A position register advances by one on every pixel clock that lies in the visible part of the line. When it wraps from the last visible position back to zero it raises a one-cycle start pulse that tells the sprite drawing logic to begin. Three further one-cycle pulses mark the counts at which the second and third copies of a duplicated sprite may begin. A reset strobe moves the sprite by forcing the position to zero at once. Because the strobe comes from a processor whose cycle spans three pixel clocks, this placement works in steps of three pixels.

Fine motion uses a move strobe and a 4-bit motion value. The strobe latches the value N and starts a train of N extra pulses, one every four pixel clocks. It also arms a flag that widens the horizontal blank which ends on the current line by eight pixel clocks. Each extra pulse that lands in blanking adds one count. One that lands in the visible region cancels that clock's normal count. A move issued at the first blank clock of a line therefore shifts the sprite by N-8 pixels. A move issued later gives a shift that depends on where the pulses land.

The block derives line timing from the blanking input alone. It expects lines of 228 pixel clocks, of which the first 68 are blank.

Top module: `hpos_counter`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `pos_o` is 0 and `draw_start`, `copy_start`, `ext_pending` are all 0.
- R2: `pos_o` stays within 0..159. On a clock with `blank_eff` low and no motion pulse it advances by one, wrapping from 159 to 0. On a clock with `blank_eff` high and no motion pulse it holds.
- R3: `draw_start` is high for exactly the one cycle after a wrap from 159 to 0, and in that cycle `pos_o` is 0.
- R4: `copy_start[0]`, `copy_start[1]` and `copy_start[2]` are each high for one cycle after the position is advanced onto 16, 32 and 64 respectively. At most one of `draw_start` and the three `copy_start` bits is high at any time.
- R5: A `res_stb` clock makes `pos_o` 0 on the next cycle with no `draw_start`. This takes priority over any advance. Counting then resumes from 0, so the copy pulses at 16, 32 and 64 still occur.
- R6: `move_stb` makes `ext_pending` 1 on the next cycle. `ext_pending` returns to 0 after the first clock of a line (the clock where `hblank_i` rises), unless `move_stb` is high on that same clock.
- R7: `blank_eff` is high whenever `hblank_i` is high. If `ext_pending` is 1 on the clock where `hblank_i` falls, `blank_eff` stays high for that clock and the seven after it. This leaves 152 visible clocks on that line.
- R8: `move_stb` latches `motion` as N and restarts the pulse train. Motion pulses occur on the 4th, 8th, ... and 4N-th clock after the strobe clock, and none occur when N is 0. A new strobe discards any pulses still pending.
- R9: A motion pulse on a blank clock (`blank_eff` high) advances the position by one. A motion pulse on a visible clock suppresses that clock's advance.
- R10: With free-running lines, a `move_stb` with value N on the first blank clock of a line shifts the position seen at the same point of the next line by N-8, modulo 160. N=0 gives -8 and N=15 gives +7. Without a move, the shift is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hblank_i | input | 1 | Normal horizontal blank from line timing, high for the first 68 clocks of a line |
| res_stb | input | 1 | One-clock strobe forcing the position to zero |
| move_stb | input | 1 | One-clock strobe starting a fine move |
| motion | input | 4 | Motion pulse count N latched by `move_stb` |
| pos_o | output | 8 | Current horizontal position, 0..159 |
| draw_start | output | 1 | One-cycle pulse after the wrap to 0 |
| copy_start | output | 3 | One-cycle pulses after reaching 16, 32, 64 |
| ext_pending | output | 1 | Move flag that widens the blank ending on this line |
| blank_eff | output | 1 | Effective blank: `hblank_i` plus the 8-clock extension |

## Verification
The hardest case to reach is a move strobe placed partway through a line. Here some motion pulses fall in blanking and some in the visible region, or the strobe comes after the blank has already ended, so the extension is lost once the next line begins. Random stimulus with a fixed seed places move and reset strobes at arbitrary clocks within free-running 228-clock lines, and also restarts pulse trains that are still running. A cycle-level bench model predicts every output for these cases. Directed lines issue the strobe on the first blank clock for several motion values and check the net shift of N-8.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
    localparam int VIS_PIX  = 160;
    localparam int POS_W    = $clog2(VIS_PIX);
    localparam int EXT_PIX  = 8;
    localparam int EXT_W    = $clog2(EXT_PIX);
    localparam int GAP      = 4;
    localparam int GAP_W    = $clog2(GAP);
    localparam int MOT_W    = 4;
    localparam int NCOPY    = 3;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [NCOPY-1:0] copy_t;

    localparam pos_t COPY_AT [NCOPY] = '{pos_t'(16), pos_t'(32), pos_t'(64)};

    typedef struct packed {
        logic [MOT_W-1:0] left;
        logic [GAP_W-1:0] phase;
    } train_t;

    typedef struct packed {
        logic             hb_q;
        logic             armed;
        logic [EXT_W-1:0] ext_left;
    } blank_st_t;

    function automatic pos_t pos_step(pos_t p);
        return (p == pos_t'(VIS_PIX - 1)) ? '0 : p + pos_t'(1);
    endfunction

    function automatic logic at_wrap(pos_t p);
        return p == pos_t'(VIS_PIX - 1);
    endfunction
endpackage

// File: rtl/hpc_motion.sv
module hpc_motion
    import hpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             move_stb,
    input  logic [MOT_W-1:0] motion,
    output logic             pulse
);
    train_t st;

    assign pulse = (st.left != '0) && (st.phase == GAP_W'(GAP - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (move_stb) begin
            st.left  <= motion;
            st.phase <= '0;
        end else if (st.left != '0) begin
            if (pulse) begin
                st.left  <= st.left - MOT_W'(1);
                st.phase <= '0;
            end else begin
                st.phase <= st.phase + GAP_W'(1);
            end
        end
    end
endmodule

// File: rtl/hpc_blank.sv
module hpc_blank
    import hpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hblank_i,
    input  logic move_stb,
    output logic blank_eff,
    output logic ext_pending
);
    blank_st_t st;
    logic line_start;
    logic widen_now;

    assign line_start  = hblank_i & ~st.hb_q;
    assign widen_now   = ~hblank_i & st.hb_q & st.armed;
    assign blank_eff   = hblank_i | widen_now | (st.ext_left != '0);
    assign ext_pending = st.armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.hb_q <= hblank_i;
            if (move_stb)
                st.armed <= 1'b1;
            else if (line_start)
                st.armed <= 1'b0;
            if (widen_now)
                st.ext_left <= EXT_W'(EXT_PIX - 1);
            else if (st.ext_left != '0)
                st.ext_left <= st.ext_left - EXT_W'(1);
        end
    end
endmodule

// File: rtl/hpc_pos.sv
module hpc_pos
    import hpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  res_stb,
    input  logic  blank_eff,
    input  logic  mpulse,
    output pos_t  pos,
    output logic  draw_start,
    output copy_t copy_start
);
    logic  adv;
    copy_t hit;

    // a motion pulse adds a count in blank and swallows one when visible
    assign adv = (~blank_eff) ^ mpulse;

    for (genvar i = 0; i < NCOPY; i++) begin : g_copy
        assign hit[i] = (pos == (COPY_AT[i] - pos_t'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst || res_stb) begin
            pos        <= '0;
            draw_start <= 1'b0;
            copy_start <= '0;
        end else if (adv) begin
            pos        <= pos_step(pos);
            draw_start <= at_wrap(pos);
            copy_start <= hit;
        end else begin
            draw_start <= 1'b0;
            copy_start <= '0;
        end
    end
endmodule

// File: rtl/hpos_counter.sv
module hpos_counter
    import hpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hblank_i,
    input  logic             res_stb,
    input  logic             move_stb,
    input  logic [MOT_W-1:0] motion,
    output logic [POS_W-1:0] pos_o,
    output logic             draw_start,
    output logic [NCOPY-1:0] copy_start,
    output logic             ext_pending,
    output logic             blank_eff
);
    logic mpulse;

    hpc_motion u_motion (
        .clk      (clk),
        .rst      (rst),
        .move_stb (move_stb),
        .motion   (motion),
        .pulse    (mpulse)
    );

    hpc_blank u_blank (
        .clk         (clk),
        .rst         (rst),
        .hblank_i    (hblank_i),
        .move_stb    (move_stb),
        .blank_eff   (blank_eff),
        .ext_pending (ext_pending)
    );

    hpc_pos u_pos (
        .clk        (clk),
        .rst        (rst),
        .res_stb    (res_stb),
        .blank_eff  (blank_eff),
        .mpulse     (mpulse),
        .pos        (pos_o),
        .draw_start (draw_start),
        .copy_start (copy_start)
    );
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker
    import hpc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             hblank_i,
    input logic             res_stb,
    input logic             move_stb,
    input logic [POS_W-1:0] pos_o,
    input logic             draw_start,
    input logic [NCOPY-1:0] copy_start,
    input logic             ext_pending,
    input logic             blank_eff
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (pos_o == '0) && !draw_start && (copy_start == '0) && !ext_pending);

    assert_pos_range_R2: assert property (@(posedge clk) disable iff (rst)
        pos_o < POS_W'(VIS_PIX));

    assert_draw_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        draw_start |-> (pos_o == '0) && ($past(pos_o) == POS_W'(VIS_PIX - 1)));

    assert_copy16_R4: assert property (@(posedge clk) disable iff (rst)
        copy_start[0] |-> pos_o == POS_W'(16));

    assert_copy32_R4: assert property (@(posedge clk) disable iff (rst)
        copy_start[1] |-> pos_o == POS_W'(32));

    assert_copy64_R4: assert property (@(posedge clk) disable iff (rst)
        copy_start[2] |-> pos_o == POS_W'(64));

    assert_one_start_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({draw_start, copy_start}));

    assert_res_zero_R5: assert property (@(posedge clk) disable iff (rst)
        res_stb |=> (pos_o == '0) && !draw_start);

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
        move_stb |=> ext_pending);

    assert_blank_cover_R7: assert property (@(posedge clk) disable iff (rst)
        hblank_i |-> blank_eff);
endmodule

bind hpos_counter hpc_checker u_checker (
    .clk         (clk),
    .rst         (rst),
    .hblank_i    (hblank_i),
    .res_stb     (res_stb),
    .move_stb    (move_stb),
    .pos_o       (pos_o),
    .draw_start  (draw_start),
    .copy_start  (copy_start),
    .ext_pending (ext_pending),
    .blank_eff   (blank_eff)
);

// File: tb/tb_hpos_counter.sv
`timescale 1ns/1ps
module tb_hpos_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hblank_i = 1'b1;
    logic       res_stb = 1'b0;
    logic       move_stb = 1'b0;
    logic [3:0] motion = 4'd0;
    logic [7:0] pos_o;
    logic       draw_start;
    logic [2:0] copy_start;
    logic       ext_pending;
    logic       blank_eff;

    always #2.5 clk = ~clk;

    hpos_counter dut (
        .clk(clk), .rst(rst), .hblank_i(hblank_i), .res_stb(res_stb),
        .move_stb(move_stb), .motion(motion), .pos_o(pos_o),
        .draw_start(draw_start), .copy_start(copy_start),
        .ext_pending(ext_pending), .blank_eff(blank_eff)
    );

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // reference state, built from the requirements
    int m_pos, m_left, m_phase, m_ext;
    bit m_armed, m_hbq, m_draw;
    bit [2:0] m_copy;
    int lc;

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_blank(bit hb);
        return hb || (!hb && m_hbq && m_armed) || (m_ext != 0);
    endfunction

    function automatic int exp_shift(int p, int n);
        return (p + n - 8 + 160) % 160;
    endfunction

    task automatic model_reset();
        m_pos = 0; m_left = 0; m_phase = 0; m_ext = 0;
        m_armed = 0; m_hbq = 0; m_draw = 0; m_copy = 0;
    endtask

    task automatic tick();
        bit hb, eb, mp, adv, widen, lstart;
        hb = (lc < 68);
        hblank_i = hb;
        #0.2;
        eb = exp_blank(hb);
        chk("R7 blank_eff", int'(blank_eff), int'(eb));
        mp = (m_left != 0) && (m_phase == 3);
        adv = (!eb) ^ mp;
        widen = !hb && m_hbq && m_armed;
        lstart = hb && !m_hbq;
        if (res_stb) begin
            m_pos = 0; m_draw = 0; m_copy = 0;
        end else if (adv) begin
            m_draw = (m_pos == 159);
            m_copy = {m_pos == 63, m_pos == 31, m_pos == 15};
            m_pos = (m_pos == 159) ? 0 : m_pos + 1;
        end else begin
            m_draw = 0; m_copy = 0;
        end
        if (move_stb) begin
            m_left = motion; m_phase = 0;
        end else if (m_left != 0) begin
            if (mp) begin m_left--; m_phase = 0; end
            else m_phase++;
        end
        if (move_stb) m_armed = 1;
        else if (lstart) m_armed = 0;
        if (widen) m_ext = 7;
        else if (m_ext != 0) m_ext--;
        m_hbq = hb;
        @(posedge clk);
        #1;
        res_stb = 0;
        move_stb = 0;
        lc = (lc + 1) % 228;
        chk("R2/R9 pos_o", int'(pos_o), m_pos);
        chk("R3 draw_start", int'(draw_start), int'(m_draw));
        chk("R4 copy_start", int'(copy_start), int'(m_copy));
        chk("R6 ext_pending", int'(ext_pending), int'(m_armed));
    endtask

    task automatic run_to_line_start();
        while (lc != 0) tick();
    endtask

    // R10: strobe on the first blank clock, compare one line later
    task automatic net_move(int n);
        int p0;
        run_to_line_start();
        p0 = pos_o;
        move_stb = 1; motion = 4'(n);
        tick();
        repeat (227) tick();
        chk("R10 net shift", int'(pos_o), exp_shift(p0, n));
    endtask

    initial begin
        int pbase;
        void'($urandom(32'h1a2b3c4d));
        repeat (4) @(posedge clk);
        #1;
        chk("R1 pos_o in reset", int'(pos_o), 0);
        chk("R1 ext_pending in reset", int'(ext_pending), 0);
        rst = 0;
        model_reset();
        lc = 0;
        hblank_i = 1;
        chk("R1 draw_start after reset", int'(draw_start), 0);
        chk("R1 copy_start after reset", int'(copy_start), 0);

        // free-running lines: no shift without a move (R10)
        repeat (2 * 228) tick();
        run_to_line_start();
        pbase = pos_o;
        repeat (228) tick();
        chk("R10 no move no shift", int'(pos_o), pbase);

        net_move(0);
        net_move(7);
        net_move(8);
        net_move(15);
        net_move(1);

        // R5: reset strobe in the visible part, copies follow later
        while (lc != 120) tick();
        res_stb = 1;
        tick();
        chk("R5 pos after res_stb", int'(pos_o), 0);
        chk("R5 no draw after res_stb", int'(draw_start), 0);
        repeat (20) tick();

        // R8: restart a running train, and a move late in the line
        while (lc != 10) tick();
        move_stb = 1; motion = 4'd12;
        tick();
        repeat (9) tick();
        move_stb = 1; motion = 4'd3;
        tick();
        repeat (300) tick();
        while (lc != 150) tick();
        move_stb = 1; motion = 4'd15;
        tick();
        repeat (400) tick();

        // random strobes at arbitrary points of the line
        for (int i = 0; i < 12000; i++) begin
            if (($urandom() % 300) == 0) res_stb = 1;
            if (($urandom() % 120) == 0) begin
                move_stb = 1;
                motion = 4'($urandom() % 16);
            end
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(190000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule